// File: doc/BRIEF.md
# Floppy Controller Switch-Register Interface

This block sits between the processor bus and the rest of a floppy disk controller. It holds eight one-bit state switches, and every bus access changes one of them. The low four address bits pick the switch and its new value, so an access that touches a register also rewrites part of the state. Two of the switches (register select A and B) and the motor switch decide what each read returns: the data byte, a status byte or the write-handshake byte. Together they also decide whether a write goes to the mode register or to the next-output byte.

The mode register sets the bit-cell length used by the serial engines. Its timer-bypass bit controls whether the selected drive's motor stays on for a programmable hold time after the motor switch is cleared. The block drives a motor-enable line to each of two drives and passes the head-control lines through. The read and write serial engines are separate blocks. They hand bytes and events to this block on plain strobes.

Top module: `fdc_swreg`

## Requirements
- R1: An access with `acc_valid` high, whether a read or a write, sets switch `acc_addr[3:1]` to `acc_addr[0]`. The switch indices are 0/1/2 = head phase 0/1/2, 3 = strobe, 4 = motor, 5 = drive select, 6 = register select A and 7 = register select B. The switch values after the access decide the effect of that same access. `rsel_a` and `rsel_b` show switches 6 and 7.
- R2: A read returns its byte on `rd_data` with `rd_valid` high in the cycle after the access. A read at an odd address returns 0xFF. A read at an even address with both select switches set also returns 0xFF.
- R3: An even-address read with both selects clear returns the data byte. If bit 7 of that byte is set, the data byte becomes 0 after the read. A `rx_valid` strobe loads `rx_byte` into the data byte, and this load wins over the clear in the same cycle.
- R4: An even-address read with select A set and select B clear returns the status byte. Bits 4:0 are mode bits 4:0, bit 5 is the motor switch, bit 6 is 0 and bit 7 is `sense_in`.
- R5: An even-address read with select B set and select A clear returns the handshake byte. Bits 5:0 are 1, bit 6 is the no-underrun flag and bit 7 is the buffer-ready flag. `eng_start` sets both flags, `eng_taken` sets ready, and `eng_underrun` clears no-underrun and sets ready.
- R6: A write with both selects set and the motor switch clear loads the mode register. The same write with the motor switch set loads `next_byte` and clears the ready flag. A clear from the write wins over an engine event in the same cycle.
- R7: `bit_cell_len` follows mode bits 4:3: 00 gives 28, 01 gives 14, 10 gives 32 and 11 gives 16.
- R8: When an access clears the motor switch while mode bit 2 (as it was before that access) is 0, the motor stays on for `CLK_HZ` more cycles. When that bit is 1, the motor goes off at once. Setting the motor switch cancels any hold still running.
- R9: `drv_enable` has at most one bit set: the bit that the drive-select switch picks, while the motor switch is on or a hold is running. Changing the drive select moves the enable to the other drive at once.
- R10: `drv_ctrl` is {`sel_in`, strobe, phase 2, phase 1, phase 0} and follows the switches and `sel_in` without delay.
- R11: Reset clears all switches, the mode register, the data byte, `next_byte` and the hold timer. It sets both handshake flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 4 | Switch index in bits 3:1, new switch value in bit 0 |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| rx_valid | input | 1 | Read engine delivers a byte |
| rx_byte | input | 8 | Byte from the read engine |
| eng_start | input | 1 | Write engine starts a write |
| eng_taken | input | 1 | Write engine took the next byte |
| eng_underrun | input | 1 | Write engine found no byte waiting |
| sense_in | input | 1 | Sense line from the selected drive |
| sel_in | input | 1 | Extra head-select input |
| rsel_a | output | 1 | Register select A switch |
| rsel_b | output | 1 | Register select B switch |
| next_byte | output | 8 | Next byte for the write engine |
| bit_cell_len | output | 6 | Bit-cell length in clocks |
| drv_enable | output | 2 | Motor enable for each drive |
| drv_ctrl | output | 5 | Head-control lines to the drives |

## Verification
The motor hold window is the hardest case to reach from the ports. A drive-select change or a motor re-enable has to land while the hold is running, and the timer-bypass bit can only be written while the motor switch is off. The bench shrinks `CLK_HZ` so that the window lasts a few dozen cycles. It then uses directed sequences to write the mode and raise and drop the motor, and it swaps drives partway through the hold. A long random phase follows, with sparse accesses, and a per-clock model compares its results against the design.

// File: rtl/fdc_swreg_pkg.sv
package fdc_swreg_pkg;
  localparam int SW_COUNT = 8;
  localparam int SW_IDX_W = $clog2(SW_COUNT);
  localparam int ADDR_W   = SW_IDX_W + 1;
  localparam int BYTE_W   = 8;
  localparam int DRIVES   = 2;
  localparam int CELL_W   = 6;
  localparam int CTRL_W   = 5;

  typedef enum logic [SW_IDX_W-1:0] {
    SW_PH0    = 3'd0,
    SW_PH1    = 3'd1,
    SW_PH2    = 3'd2,
    SW_STROBE = 3'd3,
    SW_MOTOR  = 3'd4,
    SW_UNIT   = 3'd5,
    SW_RSEL_A = 3'd6,
    SW_RSEL_B = 3'd7
  } sw_idx_e;

  typedef enum logic [1:0] {
    RD_DATA   = 2'b00,
    RD_STATUS = 2'b01,
    RD_HSHAKE = 2'b10,
    RD_NONE   = 2'b11
  } rd_sel_e;

  localparam logic [CELL_W-1:0] CELL_SLOW_LO = 6'd28;
  localparam logic [CELL_W-1:0] CELL_FAST_LO = 6'd14;
  localparam logic [CELL_W-1:0] CELL_SLOW_HI = 6'd32;
  localparam logic [CELL_W-1:0] CELL_FAST_HI = 6'd16;
endpackage

// File: rtl/fdc_switch_bank.sv
module fdc_switch_bank
  import fdc_swreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  output logic [SW_COUNT-1:0] sw_q,
  output logic [SW_COUNT-1:0] sw_next
);
  logic [SW_IDX_W-1:0] idx;
  assign idx = acc_addr[ADDR_W-1:1];

  for (genvar g = 0; g < SW_COUNT; g++) begin : g_sw
    assign sw_next[g] = (acc_valid && (idx == SW_IDX_W'(g))) ? acc_addr[0] : sw_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (acc_valid) begin
      sw_q <= sw_next;
    end
  end
endmodule

// File: rtl/fdc_motor_timer.sv
module fdc_motor_timer #(
  parameter int DELAY_CYCLES = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_now,
  input  logic en_next,
  input  logic quick_off,
  output logic running
);
  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (en_now && !en_next) begin
      cnt_d = quick_off ? '0 : LOAD;
    end else if (en_next) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign running = (cnt_q != '0);
endmodule

// File: rtl/fdc_read_mux.sv
module fdc_read_mux
  import fdc_swreg_pkg::*;
(
  input  logic              odd,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic [BYTE_W-1:0] mode_byte,
  input  logic              motor_sw,
  input  logic              sense,
  input  logic              hs_ready,
  input  logic              hs_ok,
  output logic [BYTE_W-1:0] rd_byte
);
  always_comb begin
    rd_byte = '1;
    if (!odd) begin
      unique case (rd_sel_e'(sel))
        RD_DATA:   rd_byte = data_byte;
        RD_STATUS: rd_byte = {sense, 1'b0, motor_sw, mode_byte[4:0]};
        RD_HSHAKE: rd_byte = {hs_ready, hs_ok, 6'h3F};
        default:   rd_byte = '1;
      endcase
    end
  end
endmodule

// File: rtl/fdc_swreg.sv
module fdc_swreg
  import fdc_swreg_pkg::*;
#(
  parameter int CLK_HZ = 8000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [3:0]        acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              eng_start,
  input  logic              eng_taken,
  input  logic              eng_underrun,
  input  logic              sense_in,
  input  logic              sel_in,
  output logic              rsel_a,
  output logic              rsel_b,
  output logic [7:0]        next_byte,
  output logic [5:0]        bit_cell_len,
  output logic [1:0]        drv_enable,
  output logic [4:0]        drv_ctrl
);
  localparam int HOLD_CYCLES = CLK_HZ;

  logic [SW_COUNT-1:0] sw_q, sw_next;
  logic                hold_run, motor_on;
  logic [BYTE_W-1:0]   mode_q, mode_d;
  logic [BYTE_W-1:0]   data_q, data_d;
  logic [BYTE_W-1:0]   next_q, next_d;
  logic                rdy_q, rdy_d, ok_q, ok_d;
  logic [BYTE_W-1:0]   rd_q, rd_d, mux_byte;
  logic                rdv_q, rdv_d;
  logic                rd_acc, wr_both, wr_mode, wr_next;

  fdc_switch_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .sw_q      (sw_q),
    .sw_next   (sw_next)
  );

  fdc_motor_timer #(.DELAY_CYCLES(HOLD_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_now    (sw_q[SW_MOTOR]),
    .en_next   (sw_next[SW_MOTOR]),
    .quick_off (mode_q[2]),
    .running   (hold_run)
  );

  fdc_read_mux u_mux (
    .odd       (acc_addr[0]),
    .sel       ({sw_next[SW_RSEL_B], sw_next[SW_RSEL_A]}),
    .data_byte (data_q),
    .mode_byte (mode_q),
    .motor_sw  (sw_next[SW_MOTOR]),
    .sense     (sense_in),
    .hs_ready  (rdy_q),
    .hs_ok     (ok_q),
    .rd_byte   (mux_byte)
  );

  assign rd_acc  = acc_valid && !acc_write;
  assign wr_both = acc_valid && acc_write && sw_next[SW_RSEL_A] && sw_next[SW_RSEL_B];
  assign wr_mode = wr_both && !sw_next[SW_MOTOR];
  assign wr_next = wr_both && sw_next[SW_MOTOR];

  always_comb begin
    mode_d = wr_mode ? acc_wdata : mode_q;
    next_d = wr_next ? acc_wdata : next_q;

    data_d = data_q;
    if (rd_acc && !acc_addr[0] && !sw_next[SW_RSEL_A] && !sw_next[SW_RSEL_B] && data_q[7]) begin
      data_d = '0;
    end
    if (rx_valid) begin
      data_d = rx_byte;
    end

    rdy_d = rdy_q;
    ok_d  = ok_q;
    if (eng_start) begin
      rdy_d = 1'b1;
      ok_d  = 1'b1;
    end
    if (eng_taken) begin
      rdy_d = 1'b1;
    end
    if (eng_underrun) begin
      rdy_d = 1'b1;
      ok_d  = 1'b0;
    end
    if (wr_next) begin
      rdy_d = 1'b0;
    end

    rd_d  = rd_acc ? mux_byte : rd_q;
    rdv_d = rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      next_q <= '0;
      data_q <= '0;
      rdy_q  <= 1'b1;
      ok_q   <= 1'b1;
      rd_q   <= '0;
      rdv_q  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_next) next_q <= next_d;
      data_q <= data_d;
      rdy_q  <= rdy_d;
      ok_q   <= ok_d;
      if (rd_acc) rd_q <= rd_d;
      rdv_q  <= rdv_d;
    end
  end

  always_comb begin
    unique case (mode_q[4:3])
      2'b00:   bit_cell_len = CELL_SLOW_LO;
      2'b01:   bit_cell_len = CELL_FAST_LO;
      2'b10:   bit_cell_len = CELL_SLOW_HI;
      default: bit_cell_len = CELL_FAST_HI;
    endcase
  end

  assign motor_on = sw_q[SW_MOTOR] || hold_run;

  for (genvar d = 0; d < DRIVES; d++) begin : g_drv
    assign drv_enable[d] = motor_on && (sw_q[SW_UNIT] == d[0]);
  end

  assign drv_ctrl  = {sel_in, sw_q[SW_STROBE], sw_q[SW_PH2], sw_q[SW_PH1], sw_q[SW_PH0]};
  assign rsel_a    = sw_q[SW_RSEL_A];
  assign rsel_b    = sw_q[SW_RSEL_B];
  assign next_byte = next_q;
  assign rd_data   = rd_q;
  assign rd_valid  = rdv_q;
endmodule

// File: rtl/fdc_swreg_chk.sv
module fdc_swreg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [3:0] acc_addr,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [1:0] drv_enable,
  input logic [7:0] sw_q,
  input logic [7:0] mode_q,
  input logic [5:0] bit_cell_len
);
  AST_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid); // R2
  AST_ODD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr[0]) |=> (rd_data == 8'hFF)); // R2
  AST_SINGLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv_enable) <= 1); // R9
  AST_QUICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_q[4]) && $past(mode_q[2])) |-> (drv_enable == 2'b00)); // R8
  AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_q[4]) && !$past(mode_q[2])) |-> (drv_enable != 2'b00)); // R8
  AST_FAST_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3] |-> (bit_cell_len < 6'd17)); // R7
endmodule

bind fdc_swreg fdc_swreg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_addr     (acc_addr),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .drv_enable   (drv_enable),
  .sw_q         (sw_q),
  .mode_q       (mode_q),
  .bit_cell_len (bit_cell_len)
);

// File: tb/test_fdc_swreg.sv
module test_fdc_swreg;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       eng_start = 1'b0, eng_taken = 1'b0, eng_underrun = 1'b0;
  logic       sense_in = 1'b1, sel_in = 1'b0;
  logic       rd_valid, rsel_a, rsel_b;
  logic [7:0] rd_data, next_byte;
  logic [5:0] bit_cell_len;
  logic [1:0] drv_enable;
  logic [4:0] drv_ctrl;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  fdc_swreg #(.CLK_HZ(HZ)) i_fdc_swreg (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .eng_start(eng_start), .eng_taken(eng_taken),
    .eng_underrun(eng_underrun), .sense_in(sense_in), .sel_in(sel_in),
    .rsel_a(rsel_a), .rsel_b(rsel_b), .next_byte(next_byte),
    .bit_cell_len(bit_cell_len), .drv_enable(drv_enable), .drv_ctrl(drv_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit [7:0] m_sw;
  int       m_mode, m_data, m_next, m_rd, m_timer;
  bit       m_rdy, m_ok, m_rdv;

  function automatic int cell_of(int mode);
    case ((mode >> 3) & 3)
      0: return 28;
      1: return 14;
      2: return 32;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = '0; m_mode = 0; m_data = 0; m_next = 0; m_rd = 0;
      m_timer = 0; m_rdy = 1; m_ok = 1; m_rdv = 0;
    end else begin
      bit [7:0] nsw;
      int old_mode;
      old_mode = m_mode;
      nsw = m_sw;
      if (acc_valid) nsw[acc_addr[3:1]] = acc_addr[0];
      if (m_sw[4] && !nsw[4]) m_timer = ((old_mode >> 2) & 1) ? 0 : HZ;
      else if (nsw[4]) m_timer = 0;
      else if (m_timer > 0) m_timer--;
      m_rdv = acc_valid && !acc_write;
      if (m_rdv) begin
        if (acc_addr[0]) m_rd = 255;
        else if (!nsw[7] && !nsw[6]) begin
          m_rd = m_data;
          if (m_data >= 128) m_data = 0;
        end else if (!nsw[7] && nsw[6])
          m_rd = (old_mode & 31) + (nsw[4] ? 32 : 0) + (sense_in ? 128 : 0);
        else if (nsw[7] && !nsw[6])
          m_rd = 63 + (m_ok ? 64 : 0) + (m_rdy ? 128 : 0);
        else m_rd = 255;
      end
      if (rx_valid) m_data = rx_byte;
      if (eng_start) begin m_rdy = 1; m_ok = 1; end
      if (eng_taken) m_rdy = 1;
      if (eng_underrun) begin m_rdy = 1; m_ok = 0; end
      if (acc_valid && acc_write && nsw[6] && nsw[7]) begin
        if (nsw[4]) begin m_next = acc_wdata; m_rdy = 0; end
        else m_mode = acc_wdata;
      end
      m_sw = nsw;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison, a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      int en_exp;
      en_exp = (m_sw[4] || m_timer > 0) ? (m_sw[5] ? 2 : 1) : 0;
      chk("R2 rd_valid", int'(rd_valid), int'(m_rdv));
      if (m_rdv) chk("R2/R3/R4/R5 rd_data", int'(rd_data), m_rd);
      chk("R1 rsel", int'({rsel_b, rsel_a}), int'({m_sw[7], m_sw[6]}));
      chk("R6 next_byte", int'(next_byte), m_next);
      chk("R7 bit_cell_len", int'(bit_cell_len), cell_of(m_mode));
      chk("R8/R9 drv_enable", int'(drv_enable), en_exp);
      chk("R10 drv_ctrl", int'(drv_ctrl), int'({sel_in, m_sw[3:0]}));
    end
  end

  task automatic acc(input logic [3:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk("R11 cell after reset", int'(bit_cell_len), 28);
    chk("R11 drives off after reset", int'(drv_enable), 0);
    chk("R11 next_byte after reset", int'(next_byte), 0);

    // R1 set both selects, then R7 mode lengths
    acc(4'hD, 1'b0, 8'h00);
    acc(4'hF, 1'b0, 8'h00);
    chk("R1 selects set", int'({rsel_b, rsel_a}), 3);
    chk("R2 read with both selects", int'(rd_data), 255);
    acc(4'hF, 1'b1, 8'h08); chk("R7 fast low clock", int'(bit_cell_len), 14);
    acc(4'hF, 1'b1, 8'h10); chk("R7 slow high clock", int'(bit_cell_len), 32);
    acc(4'hF, 1'b1, 8'h18); chk("R7 fast high clock", int'(bit_cell_len), 16);
    acc(4'hF, 1'b1, 8'h1B); chk("R6 mode write", int'(bit_cell_len), 16);

    // R2 odd read, R4 status read
    acc(4'h1, 1'b0, 8'h00); chk("R2 odd read", int'(rd_data), 255);
    sense_in = 1'b1;
    acc(4'hE, 1'b0, 8'h00); chk("R4 status", int'(rd_data), 8'h9B);
    sense_in = 1'b0;
    acc(4'h0, 1'b0, 8'h00); chk("R4 status sense low", int'(rd_data), 8'h1B);

    // R3 data register
    pulse_rx(8'h95);
    acc(4'hC, 1'b0, 8'h00); chk("R3 data read", int'(rd_data), 8'h95);
    acc(4'hC, 1'b0, 8'h00); chk("R3 cleared after read", int'(rd_data), 0);
    pulse_rx(8'h35);
    acc(4'hC, 1'b0, 8'h00);
    acc(4'hC, 1'b0, 8'h00); chk("R3 kept when bit7 clear", int'(rd_data), 8'h35);

    // R5 handshake read, R6 next-byte write
    acc(4'hF, 1'b0, 8'h00);
    acc(4'h0, 1'b0, 8'h00); chk("R5 handshake reset", int'(rd_data), 255);
    acc(4'hD, 1'b0, 8'h00);
    acc(4'h9, 1'b1, 8'hA5); chk("R6 next byte", int'(next_byte), 8'hA5);
    acc(4'hC, 1'b0, 8'h00); chk("R5/R6 ready cleared", int'(rd_data), 8'h7F);
    @(negedge clk); eng_underrun = 1'b1; @(negedge clk); eng_underrun = 1'b0;
    acc(4'h0, 1'b0, 8'h00); chk("R5 underrun", int'(rd_data), 8'hBF);
    @(negedge clk); eng_start = 1'b1; @(negedge clk); eng_start = 1'b0;
    acc(4'h0, 1'b0, 8'h00); chk("R5 start", int'(rd_data), 8'hFF);

    // R8/R9 hold window with a drive swap
    acc(4'hD, 1'b0, 8'h00);
    acc(4'h8, 1'b0, 8'h00);
    acc(4'hF, 1'b1, 8'h00);
    acc(4'h9, 1'b0, 8'h00); chk("R9 drive 0 on", int'(drv_enable), 1);
    acc(4'h8, 1'b0, 8'h00); chk("R8 held after clear", int'(drv_enable), 1);
    idle(15);
    acc(4'hB, 1'b0, 8'h00); chk("R9 swap during hold", int'(drv_enable), 2);
    idle(HZ);
    chk("R8 off after hold", int'(drv_enable), 0);
    acc(4'hF, 1'b1, 8'h04);
    acc(4'h9, 1'b0, 8'h00);
    acc(4'h8, 1'b0, 8'h00); chk("R8 quick off", int'(drv_enable), 0);
    sel_in = 1'b1;
    acc(4'h7, 1'b0, 8'h00);
    acc(4'h3, 1'b0, 8'h00);
    #1 chk("R10 control lines", int'(drv_ctrl), 8'h1A);

    // Random phase, compared every clock by the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      acc_valid    = ($urandom_range(0, 3) == 0);
      acc_write    = $urandom_range(0, 1) != 0;
      acc_addr     = 4'($urandom_range(0, 15));
      acc_wdata    = 8'($urandom_range(0, 255));
      rx_valid     = ($urandom_range(0, 7) == 0);
      rx_byte      = 8'($urandom_range(0, 255));
      eng_start    = ($urandom_range(0, 31) == 0);
      eng_taken    = ($urandom_range(0, 15) == 0);
      eng_underrun = ($urandom_range(0, 31) == 0);
      sense_in     = $urandom_range(0, 1) != 0;
      sel_in       = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 7) == 0) begin
        acc_valid = 1'b0; rx_valid = 1'b0;
        for (int k = 0; k < HZ / 2; k++) @(negedge clk);
      end
    end
    @(negedge clk);
    acc_valid = 1'b0; rx_valid = 1'b0;
    eng_start = 1'b0; eng_taken = 1'b0; eng_underrun = 1'b0;
    idle(HZ + 5);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule